// File: doc/BRIEF.md
# Programmable power sequencer

This block steps a power domain through a wakeup or a sleep routine. Each routine is a program of eight instructions stored in its own small memory. An instruction carries a 4-bit delay exponent and a complete set of six output levels. When a step begins, the sequencer latches the instruction and waits 2^exponent clock cycles. It then loads all six levels into the output registers at once. The outputs are core reset, pad reset, high-frequency clock reset, domain isolation and two supply enables.

The wakeup or sleep request input chooses which program runs. A busy flag is high while a program runs, and requests that arrive while busy are dropped. Both memories can be read through a word-addressed register port at any time. A write to either memory only lands when the write just before it stored the unlock value at the key address. The always-on reset drives every output high and reloads both memories with safe programs.

Top module: `pwr_seq`

## Requirements
- R1: While rst_ni is low and just after it is released, all six level outputs are 1 and busy_o is 0. The wakeup memory holds 0x3F0, 0x2F8, then 0x030 in entries 2..7. The sleep memory holds 0x3F0, 0x3C4, then 0x3C0 in entries 2..7.
- R2: Instruction layout: bits [3:0] are the delay exponent, bit 4 is supply_en_o[0], bit 5 is supply_en_o[1], bit 6 is pad_rst_o, bit 7 is core_rst_o, bit 8 is hfclk_rst_o and bit 9 is isolate_o.
- R3: A step whose exponent is e lasts exactly 2^e cycles. A whole program therefore keeps busy_o high for the sum of 2^e over its eight steps.
- R4: The level outputs change only at the edge that completes a step. Between steps, and after the last step, they hold their values.
- R5: While idle, a one-cycle pulse on wake_req_i starts the wakeup program and a pulse on sleep_req_i starts the sleep program. If both are high in the same cycle, wakeup runs.
- R6: A request that arrives while busy_o is high has no effect on the running program or on the one that follows.
- R7: busy_o rises on the edge after an accepted request. It falls on the edge that applies step 7.
- R8: reg_rdata_o always shows the addressed word, zero-extended. Addresses 0..7 are wakeup entries, 8..15 are sleep entries, and address 16 shows the unlock state in bit 0.
- R9: Writing 0x5AFEC0DE to address 16 unlocks. The next write to addresses 0..15 stores wdata[9:0]. Any write to another address relocks, and a write to address 16 with a different value relocks. A write while locked changes nothing.
- R10: A step's instruction is latched at the edge that starts the step. A memory write landing on that same edge is used from the next run on.
- R11: Instruction 0x108 holds the previous levels for 256 cycles. It then drives hfclk_rst_o high and every other level low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Always-on asynchronous reset, active low |
| wake_req_i | input | 1 | Start the wakeup program |
| sleep_req_i | input | 1 | Start the sleep program |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| busy_o | output | 1 | Program running |
| supply_en_o | output | 2 | Supply enables |
| pad_rst_o | output | 1 | Pad reset |
| core_rst_o | output | 1 | Core reset |
| hfclk_rst_o | output | 1 | High-frequency clock reset |
| isolate_o | output | 1 | Domain isolation |

## Verification
A memory write can land on the same edge at which the sequencer fetches the next step from that memory. The bench provokes this by unlocking during a wakeup run, then writing entry 1 on exactly the edge that ends the 256-cycle step 0. The collision is judged by run length: the current run must still last 263 cycles, and the next wakeup run must last 294 cycles with the new exponent. A behavioural model with a down-counting delay shadows every clock and cross-checks the levels, busy_o and the read data.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int EXP_W   = 4;
  localparam int LVL_W   = 6;
  localparam int INSTR_W = EXP_W + LVL_W;

  typedef logic [INSTR_W-1:0] instr_t;

  // field order matches instruction bits 9..4
  typedef struct packed {
    logic       isolate;
    logic       hfclk_rst;
    logic       core_rst;
    logic       pad_rst;
    logic [1:0] supply_en;
  } lvl_t;

  function automatic instr_t dflt_instr(input logic is_sleep, input int idx);
    if (!is_sleep) begin
      if (idx == 0) return 10'h3F0;
      if (idx == 1) return 10'h2F8;
      return 10'h030;
    end
    // sleep: everything up first, then drop supplies
    if (idx == 0) return 10'h3F0;
    if (idx == 1) return 10'h3C4;
    return 10'h3C0;
  endfunction
endpackage

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
  import pwr_seq_pkg::*;
#(
  parameter int                STEPS   = 8,
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEY_VAL = 32'h5AFEC0DE,
  parameter int                ADDR_W  = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output instr_t [STEPS-1:0]     wake_mem_o,
  output instr_t [STEPS-1:0]     sleep_mem_o,
  output logic                   armed_o
);
  localparam int KEY_ADDR = 2 * STEPS;
  localparam int STEP_W   = $clog2(STEPS);

  logic armed_q;
  logic key_hit;
  logic commit;

  assign key_hit = we_i && (addr_i == ADDR_W'(KEY_ADDR));
  assign commit  = we_i && armed_q && !key_hit;
  assign armed_o = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (we_i) armed_q <= key_hit && (wdata_i == KEY_VAL);
  end

  for (genvar i = 0; i < STEPS; i++) begin : g_entry
    instr_t wk_q, sl_q;
    logic   wr_wk, wr_sl;

    assign wr_wk = commit && (addr_i == ADDR_W'(i));
    assign wr_sl = commit && (addr_i == ADDR_W'(STEPS + i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    wk_q <= dflt_instr(1'b0, i);
      else if (wr_wk) wk_q <= wdata_i[INSTR_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sl_q <= dflt_instr(1'b1, i);
      else if (wr_sl) sl_q <= wdata_i[INSTR_W-1:0];
    end

    assign wake_mem_o[i]  = wk_q;
    assign sleep_mem_o[i] = sl_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < ADDR_W'(STEPS))
      rdata_o[INSTR_W-1:0] = wake_mem_o[addr_i[STEP_W-1:0]];
    else if (addr_i < ADDR_W'(KEY_ADDR))
      rdata_o[INSTR_W-1:0] = sleep_mem_o[STEP_W'(addr_i - ADDR_W'(STEPS))];
    else if (addr_i == ADDR_W'(KEY_ADDR))
      rdata_o[0] = armed_q;
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wake_req_i,
  input  logic               sleep_req_i,
  input  instr_t [STEPS-1:0] wake_mem_i,
  input  instr_t [STEPS-1:0] sleep_mem_i,
  output logic               busy_o,
  output logic               sel_o,
  output logic               step_done_o,
  output lvl_t               lvl_o
);
  localparam int CNT_W  = (1 << EXP_W) - 1;
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [CNT_W:0] ONE = 1;

  logic              busy_q, sel_q;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0]  cnt_q;
  instr_t            cur_q;
  logic [CNT_W:0]    lim;
  logic              at_lim, last;

  function automatic instr_t fetch(input logic s, input logic [STEP_W-1:0] idx);
    return s ? sleep_mem_i[idx] : wake_mem_i[idx];
  endfunction

  assign lim    = (ONE << cur_q[EXP_W-1:0]) - ONE;
  assign at_lim = ({1'b0, cnt_q} == lim);
  assign last   = (step_q == STEP_W'(STEPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sel_q  <= 1'b0;
      step_q <= '0;
      cnt_q  <= '0;
      cur_q  <= '0;
    end else if (!busy_q) begin
      if (wake_req_i || sleep_req_i) begin
        busy_q <= 1'b1;
        sel_q  <= !wake_req_i;           // wakeup wins a tie
        step_q <= '0;
        cnt_q  <= '0;
        cur_q  <= fetch(!wake_req_i, '0);
      end
    end else if (at_lim) begin
      cnt_q <= '0;
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        step_q <= step_q + STEP_W'(1);
        cur_q  <= fetch(sel_q, step_q + STEP_W'(1));
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign busy_o      = busy_q;
  assign sel_o       = sel_q;
  assign step_done_o = busy_q && at_lim;
  assign lvl_o       = lvl_t'(cur_q[INSTR_W-1:EXP_W]);
endmodule

// File: rtl/pwr_seq_out.sv
module pwr_seq_out
  import pwr_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  lvl_t lvl_i,
  output lvl_t lvl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_o <= '1;
    else if (load_i) lvl_o <= lvl_i;
  end
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int                STEPS   = 8,
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEY_VAL = 32'h5AFEC0DE,
  localparam int               ADDR_W  = $clog2(2 * STEPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wake_req_i,
  input  logic              sleep_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              busy_o,
  output logic [1:0]        supply_en_o,
  output logic              pad_rst_o,
  output logic              core_rst_o,
  output logic              hfclk_rst_o,
  output logic              isolate_o
);
  instr_t [STEPS-1:0] wake_mem, sleep_mem;
  logic               key_armed;
  logic               step_done;
  logic               run_sel;
  lvl_t               next_lvl, lvl_q;

  pwr_seq_regs #(
    .STEPS(STEPS), .DATA_W(DATA_W), .KEY_VAL(KEY_VAL), .ADDR_W(ADDR_W)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .wake_mem_o (wake_mem),
    .sleep_mem_o(sleep_mem),
    .armed_o    (key_armed)
  );

  pwr_seq_ctrl #(.STEPS(STEPS)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wake_req_i (wake_req_i),
    .sleep_req_i(sleep_req_i),
    .wake_mem_i (wake_mem),
    .sleep_mem_i(sleep_mem),
    .busy_o     (busy_o),
    .sel_o      (run_sel),
    .step_done_o(step_done),
    .lvl_o      (next_lvl)
  );

  pwr_seq_out i_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(step_done),
    .lvl_i (next_lvl),
    .lvl_o (lvl_q)
  );

  assign supply_en_o = lvl_q.supply_en;
  assign pad_rst_o   = lvl_q.pad_rst;
  assign core_rst_o  = lvl_q.core_rst;
  assign hfclk_rst_o = lvl_q.hfclk_rst;
  assign isolate_o   = lvl_q.isolate;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int                STEPS   = 8,
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEY_VAL = 32'h5AFEC0DE,
  parameter int                ADDR_W  = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wake_req_i,
  input logic               sleep_req_i,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic               busy_o,
  input logic [LVL_W-1:0]   lvl_i,
  input logic               step_done,
  input logic               run_sel,
  input logic               key_armed,
  input instr_t [STEPS-1:0] wake_mem,
  input instr_t [STEPS-1:0] sleep_mem
);
  localparam int KEY_ADDR = 2 * STEPS;

  // R4
  lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_done |=> $stable(lvl_i));

  // R7
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(step_done));

  // R5
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (wake_req_i || sleep_req_i)) |=> busy_o);

  // R6
  no_retarget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(run_sel));

  // R9
  locked_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !key_armed) |=> ($stable(wake_mem) && $stable(sleep_mem)));

  // R9
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !(reg_addr_i == ADDR_W'(KEY_ADDR) && reg_wdata_i == KEY_VAL))
      |=> !key_armed);
endmodule

bind pwr_seq pwr_seq_chk #(
  .STEPS(STEPS), .DATA_W(DATA_W), .KEY_VAL(KEY_VAL), .ADDR_W(ADDR_W)
) i_pwr_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wake_req_i (wake_req_i),
  .sleep_req_i(sleep_req_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .busy_o     (busy_o),
  .lvl_i      ({isolate_o, hfclk_rst_o, core_rst_o, pad_rst_o, supply_en_o}),
  .step_done  (step_done),
  .run_sel    (run_sel),
  .key_armed  (key_armed),
  .wake_mem   (wake_mem),
  .sleep_mem  (sleep_mem)
);

// File: tb/test_pwr_seq.sv
`timescale 1ns/1ps
module test_pwr_seq;
  localparam logic [31:0] KEY = 32'h5AFEC0DE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wake_req = 1'b0, sleep_req = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy;
  logic [1:0]  sup;
  logic        pad, core, hf, iso;
  logic [5:0]  lvl;

  int checks = 0, errors = 0;
  int busy_cnt = 0, lowhf_cnt = 0;

  always #5 clk = ~clk;

  pwr_seq i_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .wake_req_i(wake_req), .sleep_req_i(sleep_req),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .busy_o(busy), .supply_en_o(sup), .pad_rst_o(pad),
    .core_rst_o(core), .hfclk_rst_o(hf), .isolate_o(iso)
  );

  assign lvl = {iso, hf, core, pad, sup};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [9:0] m_wake[8], m_sleep[8];
  logic [9:0] m_cur;
  logic [5:0] m_lvl;
  bit         m_arm, m_busy, m_sel;
  int         m_step, m_rem;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_wake[i]  = (i == 0) ? 10'h3F0 : (i == 1) ? 10'h2F8 : 10'h030;
        m_sleep[i] = (i == 0) ? 10'h3F0 : (i == 1) ? 10'h3C4 : 10'h3C0;
      end
      m_arm = 0; m_busy = 0; m_sel = 0; m_step = 0; m_rem = 0;
      m_lvl = 6'h3F; m_cur = '0;
    end else begin
      if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin
          m_lvl = m_cur[9:4];
          if (m_step == 7) m_busy = 0;
          else begin
            m_step++;
            m_cur = m_sel ? m_sleep[m_step] : m_wake[m_step];
            m_rem = 1 << m_cur[3:0];
          end
        end
      end else if (wake_req || sleep_req) begin
        m_sel  = !wake_req;
        m_step = 0;
        m_cur  = m_sel ? m_sleep[0] : m_wake[0];
        m_rem  = 1 << m_cur[3:0];
        m_busy = 1;
      end
      if (reg_we) begin
        if (reg_addr == 5'd16) m_arm = (reg_wdata == KEY);
        else begin
          if (m_arm && reg_addr < 5'd8) m_wake[reg_addr[2:0]] = reg_wdata[9:0];
          else if (m_arm && reg_addr < 5'd16) m_sleep[reg_addr[2:0]] = reg_wdata[9:0];
          m_arm = 0;
        end
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [4:0] a);
    if (a < 5'd8)   return {22'b0, m_wake[a[2:0]]};
    if (a < 5'd16)  return {22'b0, m_sleep[a[2:0]]};
    if (a == 5'd16) return {31'b0, m_arm};
    return '0;
  endfunction

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (busy && !hf) lowhf_cnt++;
    #2;
    if (rst_n) begin
      check("R4 levels", {26'b0, lvl}, {26'b0, m_lvl});
      check("R7 busy", {31'b0, busy}, {31'b0, m_busy});
      check("R8 rdata", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_addr = 5'(a);
    #1 v = reg_rdata;
  endtask

  task automatic run(input logic w, input logic s, output int n);
    wake_req = w; sleep_req = s;
    busy_cnt = 0; lowhf_cnt = 0;
    @(negedge clk);
    wake_req = 1'b0; sleep_req = 1'b0;
    while (busy) @(negedge clk);
    #1 n = busy_cnt;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 levels in reset", {26'b0, lvl}, 32'h3F);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 levels", {26'b0, lvl}, 32'h3F);
    check("R1 busy", {31'b0, busy}, 32'h0);
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      check("R1 default memory", v,
            i < 8 ? ((i == 0) ? 32'h3F0 : (i == 1) ? 32'h2F8 : 32'h030)
                  : ((i == 8) ? 32'h3F0 : (i == 9) ? 32'h3C4 : 32'h3C0));
    end
    rd(16, v); check("R8 key locked", v, 32'h0);
    @(negedge clk);

    run(1'b1, 1'b0, n);
    check("R3 default wakeup length", n, 263);
    check("R2 wakeup final levels", {26'b0, lvl}, 32'h03);

    // R9 locked write ignored
    wr(0, 32'h108);
    rd(0, v); check("R9 locked write", v, 32'h3F0);
    wr(16, KEY);
    rd(16, v); check("R9 unlocked", v, 32'h1);
    wr(0, 32'h108);
    rd(0, v); check("R9 unlocked write", v, 32'h108);
    rd(16, v); check("R9 relock after write", v, 32'h0);
    wr(16, KEY + 1);
    wr(1, 32'h100);
    rd(1, v); check("R9 wrong key", v, 32'h2F8);
    for (int i = 1; i < 8; i++) begin
      wr(16, KEY);
      wr(i, 32'h100);
    end
    @(negedge clk);

    run(1'b1, 1'b0, n);
    check("R11 hold before 0x108 lands", lowhf_cnt, 256);
    check("R3 length 256+7", n, 263);
    check("R11 levels after 0x108", {26'b0, lvl}, 32'h10);

    run(1'b0, 1'b1, n);
    check("R3 default sleep length", n, 23);
    check("R2 sleep final levels", {26'b0, lvl}, 32'h3C);

    run(1'b1, 1'b1, n);
    check("R5 tie picks wakeup", n, 263);
    check("R5 tie levels", {26'b0, lvl}, 32'h10);

    // R6 request while busy
    sleep_req = 1'b1; busy_cnt = 0;
    @(negedge clk); sleep_req = 1'b0;
    repeat (3) @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk); wake_req = 1'b0;
    while (busy) @(negedge clk);
    #1 check("R6 length unchanged", busy_cnt, 23);
    check("R6 levels", {26'b0, lvl}, 32'h3C);
    repeat (20) @(negedge clk);
    check("R4 hold when idle", {26'b0, lvl}, 32'h3C);
    check("R7 idle", {31'b0, busy}, 32'h0);

    // R10 write on the step-1 fetch edge
    wake_req = 1'b1; busy_cnt = 0;
    @(negedge clk);
    wake_req = 1'b0;
    reg_we = 1'b1; reg_addr = 5'd16; reg_wdata = KEY;
    @(negedge clk);
    reg_we = 1'b0;
    repeat (254) @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd1; reg_wdata = 32'h205;
    @(negedge clk);
    reg_we = 1'b0;
    while (busy) @(negedge clk);
    #1 check("R10 current run unaffected", busy_cnt, 263);
    rd(1, v); check("R10 write stored", v, 32'h205);
    @(negedge clk);
    run(1'b1, 1'b0, n);
    check("R10 next run uses new entry", n, 294);
    check("R2 final levels", {26'b0, lvl}, 32'h10);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule